// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host access to a bank of internal configuration registers through a small directly mapped window. The window has three host-visible words: a status word that carries a ready flag and a sticky overrun flag, a control word that takes an internal register address and a write-enable bit, and a data word that carries the value that moves between the host and the bank.

To write an internal register, the host loads the data word and then writes the control word with the write-enable bit set. To read one, the host writes the control word with the write-enable bit clear, waits until ready returns, and then reads the data word. Writing the control word starts the internal cycle. Only one internal cycle runs at a time.

The bank model inside the block gives each access a latency set by a parameter. Addresses at or above a configurable boundary belong to a slow class, which stands in for registers behind a management bus. Those addresses take a much longer latency than ordinary configuration registers.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the status word at host offset 0 reads ready (bit 0) as 1 and overrun (bit 1) as 0. The data word at host offset 2 reads 0, and every internal register reads back as 0.
- R2: A control word write at host offset 1 while ready is 1 starts an access, and ready reads 0 from the cycle after that write.
- R3: An access to an internal address below SLOW_BASE keeps ready at 0 for exactly FAST_LAT cycles.
- R4: An access to an internal address at or above SLOW_BASE keeps ready at 0 for exactly SLOW_LAT cycles.
- R5: A control word with bit 15 (write enable) set copies the data word into the addressed internal register when the access completes.
- R6: A control word with bit 15 clear loads the data word with the addressed internal register's value when the access completes.
- R7: A control word write while ready is 0 does not start or change an access, and it sets the overrun flag. The flag then stays set until reset.
- R8: A data word write while ready is 0 leaves the data word unchanged, and it sets the overrun flag.
- R9: A completed write access leaves the data word unchanged. The data word changes only when a read access completes or when the host writes it while ready is 1.
- R10: The internal address is taken only from the low ADDR_W bits of the control word. Bits other than those and bit 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Window word offset: 0 status, 1 control, 2 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the word selected by host_addr (combinational) |

## Verification
The assertions assume that host_wr is a single-cycle strobe aimed at a known window offset. They also assume that the internal counter always starts from a latency loaded at acceptance, so busy can fall only after that counter reaches zero. The directed stimulus drives each write for exactly one clock, applies it between edges, and waits on the ready flag before it issues the next access. The only exceptions are the two scenarios that deliberately write while busy, to exercise the overrun path.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int FAST_LAT  = 2,
  parameter int SLOW_LAT  = 40,
  parameter int SLOW_BASE = 48,
  parameter int WE_BIT    = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(SLOW_LAT + 1);
  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [ADDR_W:0] SLOW_FROM = SLOW_BASE[ADDR_W:0];
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_LAT - 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_LAT - 1);

  logic              busy, we_q, ovr;
  logic [ADDR_W-1:0] tgt;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] bank [DEPTH];

  wire ctrl_hit = host_wr && (host_addr == OFS_CTRL);
  wire data_hit = host_wr && (host_addr == OFS_DATA);
  wire start    = ctrl_hit && !busy;
  wire done     = busy && (cnt == '0);
  wire [ADDR_W-1:0] new_tgt = host_wdata[ADDR_W-1:0];
  wire new_slow = {1'b0, new_tgt} >= SLOW_FROM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      we_q <= 1'b0;
      tgt  <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      we_q <= host_wdata[WE_BIT];
      tgt  <= new_tgt;
      cnt  <= new_slow ? SLOW_LOAD : FAST_LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovr <= 1'b0;
    else if ((ctrl_hit || data_hit) && busy)
      ovr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (done && !we_q)
      data_q <= bank[tgt];
    else if (data_hit && !busy)
      data_q <= host_wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (done && we_q) begin
      bank[tgt] <= data_q;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_STAT: host_rdata = {30'd0, ovr, !busy};
      OFS_CTRL: begin
        host_rdata[ADDR_W-1:0] = tgt;
        host_rdata[WE_BIT]     = we_q;
      end
      OFS_DATA: host_rdata = 32'(data_q);
      default:  host_rdata = '0;
    endcase
  end
endmodule

module ind_reg_bridge_chk #(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic              busy,
  input logic              we_q,
  input logic              ovr,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] data_q
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && !busy) |=> busy);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  // R7
  ctrl_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && busy) |=> ovr);
  // R8
  data_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd2 && busy) |=> ovr);
  // R9
  wr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we_q) |=> $stable(data_q));
  // R3
  early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .busy(busy), .we_q(we_q), .ovr(ovr), .cnt(cnt), .data_q(data_q)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  localparam int FAST = 2;
  localparam int SLOW = 40;
  localparam logic [31:0] WE = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  ind_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    logic [31:0] s;
    n = 0;
    rd(2'd0, s);
    while (s[0] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      rd(2'd0, s);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ind_read(input logic [31:0] ctrl, output logic [31:0] d, output int n);
    hw(2'd1, ctrl);
    wait_ready(n);
    rd(2'd2, d);
  endtask

  task automatic ind_write(input logic [31:0] ctrl, input logic [31:0] v, output int n);
    hw(2'd2, v);
    hw(2'd1, ctrl | WE);
    wait_ready(n);
  endtask

  task automatic t_reset;
    logic [31:0] d; int n;
    do_reset();
    rd(2'd0, d); check("R1 status", d, 32'h1);
    rd(2'd2, d); check("R1 data", d, 32'h0);
    ind_write(32'd9, 32'hDEAD_BEEF, n);
    do_reset();
    ind_read(32'd9, d, n); check("R1 bank cleared", d, 32'h0);
  endtask

  task automatic t_fast;
    logic [31:0] d, s; int n;
    do_reset();
    hw(2'd2, 32'hA5A5_1234);
    hw(2'd1, WE | 32'd5);
    rd(2'd0, s); check("R2 ready low", s & 32'h1, 32'h0);
    wait_ready(n); check("R3 fast write latency", n, FAST - 1 + 1);
    rd(2'd2, d); check("R9 data kept after write", d, 32'hA5A5_1234);
    hw(2'd2, 32'h0);
    ind_read(32'd5, d, n);
    check("R3 fast read latency", n, FAST);
    check("R5 R6 read back", d, 32'hA5A5_1234);
    ind_read(32'd47, d, n); check("R3 boundary 47 fast", n, FAST);
    check("R6 empty reg", d, 32'h0);
  endtask

  task automatic t_slow;
    logic [31:0] d; int n;
    do_reset();
    ind_write(32'd48, 32'h0BAD_F00D, n); check("R4 slow write 48", n, SLOW);
    ind_read(32'd48, d, n); check("R4 slow read 48", n, SLOW);
    check("R5 slow data", d, 32'h0BAD_F00D);
    ind_read(32'd63, d, n); check("R4 slow 63", n, SLOW);
  endtask

  task automatic t_ctrl_overrun;
    logic [31:0] d, s; int n;
    do_reset();
    ind_write(32'd10, 32'h1111_1111, n);
    ind_write(32'd11, 32'h2222_2222, n);
    hw(2'd1, 32'd50);
    repeat (3) @(negedge clk);
    hw(2'd1, 32'd11);
    wait_ready(n); check("R7 first access latency kept", n, SLOW - 4);
    rd(2'd2, d); check("R7 busy ctrl ignored", d, 32'h0);
    rd(2'd0, s); check("R7 overrun set", s, 32'h3);
    ind_read(32'd10, d, n); check("R7 later access ok", d, 32'h1111_1111);
    rd(2'd0, s); check("R7 overrun sticky", s, 32'h3);
  endtask

  task automatic t_data_overrun;
    logic [31:0] d, s; int n;
    do_reset();
    hw(2'd2, 32'hCAFE_0001);
    hw(2'd1, WE | 32'd52);
    hw(2'd2, 32'h7777_7777);
    rd(2'd0, s); check("R8 overrun set", s, 32'h2);
    wait_ready(n);
    rd(2'd2, d); check("R8 data unchanged", d, 32'hCAFE_0001);
    ind_read(32'd52, d, n); check("R8 bank got original", d, 32'hCAFE_0001);
  endtask

  task automatic t_mask;
    logic [31:0] d; int n;
    do_reset();
    ind_write(32'hABCD_FFC3, 32'h5A5A_A5A5, n); check("R10 masked latency", n, FAST);
    ind_read(32'd3, d, n); check("R10 low bits select reg", d, 32'h5A5A_A5A5);
    ind_read(32'h1234_7FC3, d, n); check("R10 upper bits ignored", d, 32'h5A5A_A5A5);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fast();
    t_slow();
    t_ctrl_overrun();
    t_data_overrun();
    t_mask();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule